// File: doc/BRIEF.md
# Parallel Group Rule Selector

This block sits in front of, and behind, a set of independent rule-lookup pipelines, one per rule subgroup. It accepts packet headers on several lanes, two by default because the node memories behind it are dual-ported and can serve two lookups per clock. It hands every accepted header to all group pipelines at once. The pipelines run freely and may have different depths. Each returns, for every header, a match flag, a rule index and a priority number. The internals of the pipelines and the way the rules were split are outside this block.

Inside, the selector holds each group's result back by the difference between that group's depth and the deepest group's depth. The answers for one header therefore meet in a single cycle. It then picks the winner. A smaller priority number means a stronger rule. Equal numbers go to the group with the lower index. The winner leaves on a one-cycle output pulse. When no group matched, the pulse carries a no-match flag. Results leave in the order the headers arrived, one result per header, at a fixed latency.

Top module: `pgsel_top`

## Requirements
- R1: For each lane, `grp_vld` and `grp_hdr` repeat that lane's `in_vld` and `in_hdr` exactly one cycle after the cycle in which they were presented, unchanged and shared by all groups.
- R2: Each header accepted on a lane produces exactly one `out_vld` pulse on that lane. The pulse comes MAXLAT+2 cycles after the header was presented, where MAXLAT is the largest group latency. Results come out in arrival order, and `out_vld` stays low in every other cycle.
- R3: The result of group g, for a header broadcast in cycle c, is taken from the group's result ports in cycle c+GRP_LAT[g]. GRP_LAT[g] is the 8-bit field at bit g*8 of parameter `GRP_LAT`, with a value from 1 to 255. Groups with unequal latencies are combined correctly.
- R4: Among the groups whose hit flag is high for a header, the one with the smallest priority number wins. `out_rule` and `out_prio` carry that group's rule index and priority.
- R5: When several hitting groups share the smallest priority number, the group with the lowest index wins.
- R6: When no group hits, the result has `out_vld`=1, `out_nomatch`=1, `out_rule`=0 and `out_prio`=0. When a group wins, `out_nomatch`=0.
- R7: Lanes are independent. Headers presented on both lanes in the same cycle are each resolved against their own group results.
- R8: While `rst` is high, `grp_vld` and `out_vld` are low.
- R9: Some group results have no effect on any output: those whose hit flag is low, whatever their rule and priority fields hold, and those that arrive with the hit flag high in a cycle that does not line up with a broadcast header of that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | LANES | Header valid, one bit per lane |
| in_hdr | input | LANES*HDR_W | Header per lane, lane l at bits l*HDR_W |
| grp_vld | output | LANES | Broadcast valid to all group pipelines |
| grp_hdr | output | LANES*HDR_W | Broadcast header to all group pipelines |
| grp_res_hit | input | LANES*NGRP | Group hit flag, lane l group g at bit l*NGRP+g |
| grp_res_rule | input | LANES*NGRP*12 | Group rule index, 12 bits per lane and group |
| grp_res_prio | input | LANES*NGRP*8 | Group priority number, 8 bits per lane and group |
| out_vld | output | LANES | Final result pulse per lane |
| out_nomatch | output | LANES | No group matched |
| out_rule | output | LANES*12 | Winning rule index |
| out_prio | output | LANES*8 | Winning priority number |

## Verification
The assertions run on every cycle. They check that the arbiter's winner has a priority no worse than any other hitting candidate, that ties resolve towards the lower group, that a reported winner really was a hitting candidate, that a no-match result carries zero fields, and that an in-flight counter never underflows or exceeds the pipeline occupancy. Other properties can only be shown by the bench's scenarios, driven through a behavioural model of the group pipelines with their own depths: the exact cycle and order of each result, the correct pairing of unequally delayed group results, and the dropping of stray hit results from idle slots.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;

    localparam int RULE_W  = 12;
    localparam int PRIO_W  = 8;
    localparam int MAX_GRP = 4;
    localparam int LAT_W   = 8;

    typedef logic [RULE_W-1:0] rule_t;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  hit;
        rule_t rule;
        prio_t prio;
    } res_t;

    localparam res_t RES_NONE = '0;

    // Latency of group g taken from a packed latency vector
    function automatic int lat_at(logic [MAX_GRP*LAT_W-1:0] v, int g);
        return int'(v[g*LAT_W +: LAT_W]);
    endfunction

    // Deepest latency among the first n groups
    function automatic int max_lat(logic [MAX_GRP*LAT_W-1:0] v, int n);
        int m;
        m = 0;
        for (int g = 0; g < n; g++) begin
            if (lat_at(v, g) > m) m = lat_at(v, g);
        end
        return m;
    endfunction

    // True when candidate a strictly beats incumbent b (lower number wins)
    function automatic logic beats(res_t a, res_t b);
        return a.hit && (!b.hit || (a.prio < b.prio));
    endfunction

endpackage

// File: rtl/pgsel_delay.sv
module pgsel_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pgsel_arb.sv
module pgsel_arb
    import pgsel_pkg::*;
#(
    parameter int NGRP = 3
) (
    input  logic clk,
    input  logic rst,
    input  res_t cand [NGRP],
    output res_t win
);
    localparam int GI_W = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [GI_W-1:0] win_grp;

    // Linear scan: strict comparison keeps the earlier group on a tie
    always_comb begin
        win     = RES_NONE;
        win_grp = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (beats(cand[g], win)) begin
                win     = cand[g];
                win_grp = GI_W'(g);
            end
        end
    end

    p_win_real_r9: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> (cand[win_grp].hit && cand[win_grp].rule == win.rule));

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_chk
            p_best_prio_r4: assert property (@(posedge clk) disable iff (rst)
                (cand[g].hit) |-> (win.hit && cand[g].prio >= win.prio));
            p_tie_low_r5: assert property (@(posedge clk) disable iff (rst)
                (win.hit && cand[g].hit && cand[g].prio == win.prio)
                    |-> (GI_W'(g) >= win_grp));
        end
    endgenerate
endmodule

// File: rtl/pgsel_lane.sv
module pgsel_lane
    import pgsel_pkg::*;
#(
    parameter int NGRP = 3,
    parameter logic [MAX_GRP*LAT_W-1:0] LAT_X = '0,
    parameter int MAXLAT = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   slot,
    input  logic [NGRP-1:0]        res_hit,
    input  logic [NGRP*RULE_W-1:0] res_rule,
    input  logic [NGRP*PRIO_W-1:0] res_prio,
    output logic                   out_vld,
    output logic                   out_nomatch,
    output rule_t                  out_rule,
    output prio_t                  out_prio
);
    res_t raw  [NGRP];
    res_t algn [NGRP];
    res_t win;
    logic slot_al;

    // Equalise every group to the deepest one
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int DLY = MAXLAT - lat_at(LAT_X, g);
            assign raw[g] = '{hit:  res_hit[g],
                              rule: res_rule[g*RULE_W +: RULE_W],
                              prio: res_prio[g*PRIO_W +: PRIO_W]};
            pgsel_delay #(.W($bits(res_t)), .DEPTH(DLY)) u_dly (
                .clk (clk),
                .rst (rst),
                .d   (raw[g]),
                .q   (algn[g])
            );
        end
    endgenerate

    // Slot marker travels with the deepest group
    pgsel_delay #(.W(1), .DEPTH(MAXLAT)) u_slot (
        .clk (clk),
        .rst (rst),
        .d   (slot),
        .q   (slot_al)
    );

    pgsel_arb #(.NGRP(NGRP)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .cand (algn),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld     <= 1'b0;
            out_nomatch <= 1'b0;
            out_rule    <= '0;
            out_prio    <= '0;
        end else begin
            out_vld     <= slot_al;
            out_nomatch <= slot_al && !win.hit;
            out_rule    <= (slot_al && win.hit) ? win.rule : '0;
            out_prio    <= (slot_al && win.hit) ? win.prio : '0;
        end
    end

    p_miss_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_nomatch) |-> (out_rule == '0 && out_prio == '0));
    p_flag_in_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        out_nomatch |-> out_vld);
endmodule

// File: rtl/pgsel_top.sv
module pgsel_top
    import pgsel_pkg::*;
#(
    parameter int NGRP  = 3,
    parameter int LANES = 2,
    parameter int HDR_W = 32,
    parameter logic [NGRP*LAT_W-1:0] GRP_LAT = {8'd2, 8'd5, 8'd3}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             in_vld,
    input  logic [LANES*HDR_W-1:0]       in_hdr,
    output logic [LANES-1:0]             grp_vld,
    output logic [LANES*HDR_W-1:0]       grp_hdr,
    input  logic [LANES*NGRP-1:0]        grp_res_hit,
    input  logic [LANES*NGRP*RULE_W-1:0] grp_res_rule,
    input  logic [LANES*NGRP*PRIO_W-1:0] grp_res_prio,
    output logic [LANES-1:0]             out_vld,
    output logic [LANES-1:0]             out_nomatch,
    output logic [LANES*RULE_W-1:0]      out_rule,
    output logic [LANES*PRIO_W-1:0]      out_prio
);
    localparam logic [MAX_GRP*LAT_W-1:0] LAT_X = (MAX_GRP*LAT_W)'(GRP_LAT);
    localparam int MAXLAT = max_lat(LAT_X, NGRP);
    localparam int TOTAL  = MAXLAT + 2;
    localparam int CNT_W  = $clog2(TOTAL + 1) + 1;

    // Broadcast stage shared by every group pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            grp_vld <= '0;
            grp_hdr <= '0;
        end else begin
            grp_vld <= in_vld;
            grp_hdr <= in_hdr;
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            pgsel_lane #(.NGRP(NGRP), .LAT_X(LAT_X), .MAXLAT(MAXLAT)) u_lane (
                .clk         (clk),
                .rst         (rst),
                .slot        (grp_vld[l]),
                .res_hit     (grp_res_hit[l*NGRP +: NGRP]),
                .res_rule    (grp_res_rule[l*NGRP*RULE_W +: NGRP*RULE_W]),
                .res_prio    (grp_res_prio[l*NGRP*PRIO_W +: NGRP*PRIO_W]),
                .out_vld     (out_vld[l]),
                .out_nomatch (out_nomatch[l]),
                .out_rule    (out_rule[l*RULE_W +: RULE_W]),
                .out_prio    (out_prio[l*PRIO_W +: PRIO_W])
            );

            // Occupancy counter used only by the checks below
            logic [CNT_W-1:0] inflight;
            always_ff @(posedge clk) begin
                if (rst) inflight <= '0;
                else     inflight <= inflight + CNT_W'(in_vld[l]) - CNT_W'(out_vld[l]);
            end

            p_no_orphan_r2: assert property (@(posedge clk) disable iff (rst)
                out_vld[l] |-> (inflight != '0));
            p_bounded_r2: assert property (@(posedge clk) disable iff (rst)
                inflight <= CNT_W'(TOTAL));
        end
    endgenerate
endmodule

// File: tb/sim_pgsel_top.sv
`timescale 1ns/1ps
module sim_pgsel_top;
    localparam int NG = 3;
    localparam int NL = 2;
    localparam int HW = 32;
    localparam int RW = 12;
    localparam int PW = 8;
    localparam logic [23:0] LATS = {8'd2, 8'd5, 8'd3};
    localparam int MAXL  = 5;
    localparam int TOTAL = MAXL + 2;
    localparam int NID   = 512;

    logic clk = 1'b0;
    logic rst;
    logic [NL-1:0]       in_vld;
    logic [NL*HW-1:0]    in_hdr;
    logic [NL-1:0]       grp_vld;
    logic [NL*HW-1:0]    grp_hdr;
    logic [NL*NG-1:0]    res_hit;
    logic [NL*NG*RW-1:0] res_rule;
    logic [NL*NG*PW-1:0] res_prio;
    logic [NL-1:0]       out_vld;
    logic [NL-1:0]       out_nomatch;
    logic [NL*RW-1:0]    out_rule;
    logic [NL*PW-1:0]    out_prio;

    pgsel_top #(.NGRP(NG), .LANES(NL), .HDR_W(HW), .GRP_LAT(LATS)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_hdr(in_hdr),
        .grp_vld(grp_vld), .grp_hdr(grp_hdr),
        .grp_res_hit(res_hit), .grp_res_rule(res_rule), .grp_res_prio(res_prio),
        .out_vld(out_vld), .out_nomatch(out_nomatch),
        .out_rule(out_rule), .out_prio(out_prio)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;
    int nid   = 0;

    bit    s_hit  [NID][NG];
    int    s_prio [NID][NG];
    int    s_rule [NID][NG];
    string s_tag  [NID];

    int q_id  [NL][1024];
    int q_due [NL][1024];
    int qh [NL];
    int qt [NL];

    bit hist_vld [NL][64];
    int hist_id  [NL][64];

    logic [NL-1:0]    bc_vld;
    logic [NL*HW-1:0] bc_hdr;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic defs(input bit [2:0] h, input int p0, input int p1, input int p2,
                        input string tag);
        s_hit[nid][0] = h[0]; s_hit[nid][1] = h[1]; s_hit[nid][2] = h[2];
        s_prio[nid][0] = p0;  s_prio[nid][1] = p1;  s_prio[nid][2] = p2;
        for (int g = 0; g < NG; g++) s_rule[nid][g] = (nid * 4 + g + 1) & 12'hFFF;
        s_tag[nid] = tag;
        nid++;
    endtask

    // Spec model: smallest priority among hits, lowest group on ties
    function automatic logic [21:0] expect_of(int id);
        int w;
        w = -1;
        for (int g = 0; g < NG; g++) begin
            if (s_hit[id][g] && (w < 0 || s_prio[id][g] < s_prio[id][w])) w = g;
        end
        if (w < 0) return {1'b1, 1'b1, 12'd0, 8'd0};
        return {1'b1, 1'b0, 12'(s_rule[id][w]), 8'(s_prio[id][w])};
    endfunction

    task automatic push(input int l, input int id);
        in_vld[l] = 1'b1;
        in_hdr[l*HW +: HW] = 32'hC0DE0000 | id;
        q_id[l][qt[l]]  = id;
        q_due[l][qt[l]] = cyc + TOTAL;
        qt[l]++;
    endtask

    task automatic step(input int a, input int b);
        if (a >= 0) push(0, a);
        if (b >= 0) push(1, b);
        @(negedge clk);
        in_vld = '0;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        bc_vld = in_vld;
        bc_hdr = in_hdr;
    end

    always @(negedge clk) begin
        if (rst) begin
            chk(out_vld == '0 && grp_vld == '0, "R8", "reset outputs",
                {out_vld, grp_vld}, 0);
        end else begin
            for (int l = 0; l < NL; l++) begin
                chk(grp_vld[l] == bc_vld[l] &&
                    (!bc_vld[l] || grp_hdr[l*HW +: HW] == bc_hdr[l*HW +: HW]),
                    "R1", "broadcast", grp_hdr[l*HW +: HW], bc_hdr[l*HW +: HW]);
                if (qh[l] < qt[l] && q_due[l][qh[l]] == cyc) begin
                    logic [21:0] e, a;
                    int id;
                    id = q_id[l][qh[l]];
                    e = expect_of(id);
                    a = {out_vld[l], out_nomatch[l], out_rule[l*RW +: RW], out_prio[l*PW +: PW]};
                    chk(a == e, s_tag[id], $sformatf("result lane %0d id %0d", l, id), a, e);
                    qh[l]++;
                end else begin
                    chk(out_vld[l] == 1'b0, "R2", $sformatf("idle lane %0d", l), out_vld[l], 0);
                end
            end
        end
        // Behavioural group pipelines, each with its own depth
        for (int l = 0; l < NL; l++) begin
            hist_vld[l][cyc % 64] = grp_vld[l];
            hist_id[l][cyc % 64]  = int'(grp_hdr[l*HW +: 16]);
            for (int g = 0; g < NG; g++) begin
                int k, t, id;
                k = l * NG + g;
                t = cyc - int'(LATS[g*8 +: 8]);
                if (t >= 0 && hist_vld[l][t % 64]) begin
                    id = hist_id[l][t % 64];
                    res_hit[k] = s_hit[id][g];
                    res_rule[k*RW +: RW] = s_hit[id][g] ? 12'(s_rule[id][g]) : 12'h555;
                    res_prio[k*PW +: PW] = s_hit[id][g] ? 8'(s_prio[id][g]) : 8'd0;
                end else begin
                    // stray hit with the strongest priority: must be dropped (R9)
                    res_hit[k] = 1'b1;
                    res_rule[k*RW +: RW] = 12'hABC;
                    res_prio[k*PW +: PW] = 8'd0;
                end
            end
        end
    end

    initial begin
        rst = 1'b1;
        in_vld = '0;
        in_hdr = '0;
        qh[0] = 0; qh[1] = 0; qt[0] = 0; qt[1] = 0;
        defs(3'b111, 9, 4, 7, "R4");      // 0: group 1 wins
        defs(3'b101, 8, 0, 1, "R4");      // 1: group 2 wins
        defs(3'b111, 3, 3, 3, "R5");      // 2: three-way tie, group 0
        defs(3'b110, 0, 2, 2, "R5");      // 3: tie of groups 1 and 2, group 1
        defs(3'b000, 1, 1, 1, "R6");      // 4: no match
        defs(3'b100, 0, 0, 200, "R9");    // 5: non-hit fields with prio 0 ignored
        defs(3'b010, 0, 6, 0, "R3");      // 6: deepest group only
        defs(3'b100, 0, 0, 6, "R3");      // 7: shallowest group only
        defs(3'b001, 6, 0, 0, "R3");      // 8: middle group only
        for (int i = 0; i < 400; i++) begin
            defs(3'($urandom_range(0, 7)), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 7), "R7");
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        step(0, -1);  repeat (9) @(negedge clk);
        step(-1, 1);  repeat (9) @(negedge clk);
        step(2, 3);
        step(4, 5);
        step(6, 7);
        step(8, -1);
        step(-1, 8);
        step(5, 4);
        repeat (10) @(negedge clk);
        begin
            int id;
            id = 9;
            for (int c = 0; c < 400 && id < nid; c++) begin
                int a, b;
                a = -1; b = -1;
                if ($urandom_range(0, 3) != 0 && id < nid) begin a = id; id++; end
                if ($urandom_range(0, 3) != 0 && id < nid) begin b = id; id++; end
                step(a, b);
            end
        end
        repeat (TOTAL + 3) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(qh[l] == qt[l], "R2", $sformatf("all results delivered lane %0d", l), qh[l], qt[l]);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule